// File: doc/BRIEF.md
# USB Host Command and Status Register Unit

This block holds the command and status registers of a USB host controller and the control logic that links them to the schedule engine. Software reaches both registers, and a read-only frame index, through a simple 32-bit register port with a write strobe and a combinational read. The block drives the run and periodic-enable controls for the transaction engine. It also produces a self-timed soft reset pulse and the byte offset of the current frame-list entry.

Stopping is a handshake. Clearing the run bit drops `sched_run` at once. The halted flag is set only after the transaction engine reports that nothing is in flight. A soft reset always runs its full fixed length. During that time every other register write and the busy input are ignored. The frame-list size is a 3-bit code held in two separate places in the command word. It chooses how many low bits of a 14-bit frame counter form the frame-list pointer.

Top module: `usbh_cmdsts`

## Requirements
- R1: After `rst_n` is asserted, the command word reads 0x00000000 and the status word reads 0x00001000 (halted, bit 12, is 1). `sched_run`, `periodic_en` and `soft_rst` are 0.
- R2: The command word is at offset 0x140: bit 0 run, bit 1 reset, bit 4 periodic enable, and the size code is {bit 15, bit 3, bit 2}. The status word is at 0x144: flags in bits 5:0, halted in bit 12. The frame index is at 0x14C, bits 13:0. Any other offset reads 0.
- R3: A command write with bit 0 = 1 while halted raises `sched_run` on the following cycle. Halted falls one cycle after that.
- R4: A command write with bit 0 = 1 while neither running nor halted (a stop still pending) leaves `sched_run` at 0.
- R5: After run is cleared, halted stays 0 while `xact_busy` is 1. Halted becomes 1 on the first clock edge that samples run = 0 and `xact_busy` = 0.
- R6: A command write with bit 1 = 1 raises `soft_rst` for exactly 16 cycles, starting the cycle after the write, and command bit 1 reads 1 for that time. Afterwards the command word reads 0, the flags and frame index are 0, and halted is 1.
- R7: While `soft_rst` is 1, register writes have no effect, including a write of 0 to bit 1. `evt_set` and `xact_busy` are ignored too, and the reset cannot be cut short.
- R8: Command bit 4 is read/write and drives `periodic_en`.
- R9: The size code takes written values only while `cap_prog_fl` = 1. Otherwise it keeps its value (000 after reset).
- R10: The frame index adds 1 (modulo 2^14) at each edge where `frame_tick` and `sched_run` are both 1. Otherwise it holds.
- R11: `fl_offset` = 4 × (index mod (1024 >> code)), taken combinationally from the current registers. Code 000 gives 1024 entries and code 111 gives 8.
- R12: A 1 on `evt_set[i]` sets status flag i on the next edge. Writing 1 to status bit i clears it, and writing 0 leaves it. When a set and a clear meet in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_prog_fl | input | 1 | Capability: frame-list size is programmable |
| xact_busy | input | 1 | Transaction engine has a transaction in flight |
| frame_tick | input | 1 | One pulse per frame |
| evt_set | input | 6 | Set pulses for status flags 5:0 |
| sched_run | output | 1 | Schedule execution enabled |
| periodic_en | output | 1 | Periodic schedule processing allowed |
| soft_rst | output | 1 | Controller soft reset in progress |
| fl_offset | output | 12 | Byte offset of the current frame-list entry |

## Verification
The results fall due at different times. Register reads and `fl_offset` are combinational, so they are valid in the same cycle. Written fields and `sched_run` change on the edge that takes the write. Halted falls one edge after run rises, and it rises one edge after busy is seen low. Inputs are driven on the falling clock edge and results are sampled on the next falling edge, so each rising edge on the way is counted once. The reset pulse is counted at the falling edges, with writes, events and busy applied inside it. The offset is compared arithmetically for all eight size codes at many index values, including the wrap of the 14-bit counter.

// File: rtl/usbh_cs_pkg.sv
package usbh_cs_pkg;
  localparam int unsigned NFLAG      = 6;
  localparam logic [11:0] OFS_CMD    = 12'h140;
  localparam logic [11:0] OFS_STS    = 12'h144;
  localparam logic [11:0] OFS_FIDX   = 12'h14C;
  localparam int unsigned B_RUN      = 0;
  localparam int unsigned B_RST      = 1;
  localparam int unsigned B_FS0      = 2;
  localparam int unsigned B_FS1      = 3;
  localparam int unsigned B_PEN      = 4;
  localparam int unsigned B_FS2      = 15;
  localparam int unsigned B_HALT     = 12;
  typedef logic [2:0] fl_code_t;
endpackage

// File: rtl/usbh_rstseq.sv
module usbh_rstseq #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end else if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R7: once under way, a reset is not cut short
  p_no_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CW'(1)) |=> active);
endmodule

// File: rtl/usbh_runctl.sv
module usbh_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_cmd,
  input  logic wr_run,
  input  logic busy,
  output logic run,
  output logic halted
);
  logic run_d, halted_d;

  always_comb begin
    run_d = run;
    if (clr)         run_d = 1'b0;
    else if (wr_cmd) run_d = wr_run & (halted | run);
  end

  always_comb begin
    if (clr)       halted_d = 1'b1;
    else if (run)  halted_d = 1'b0;
    else if (busy) halted_d = halted;
    else           halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      halted <= 1'b1;
    end else begin
      run    <= run_d;
      halted <= halted_d;
    end
  end

  // R3: one cycle after run rises, halted is clear
  p_start_clears_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> !halted);
  // R4: no restart while a stop is still pending
  p_no_restart_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !halted && !run && !clr) |=> !run);
  // R5: halted rises only after an idle cycle with run low
  p_halt_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halted) && !$past(clr)) |-> (!$past(busy) && !$past(run)));
endmodule

// File: rtl/usbh_frindex.sv
module usbh_frindex
  import usbh_cs_pkg::*;
#(
  parameter int unsigned FIDX_W  = 14,
  parameter int unsigned LOG2MAX = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 tick,
  input  logic                 run,
  input  fl_code_t             code,
  output logic [FIDX_W-1:0]    idx,
  output logic [LOG2MAX+1:0]   offset
);
  logic [FIDX_W-1:0]  idx_d;
  logic               idx_en;
  logic [LOG2MAX-1:0] keep;

  always_comb begin
    idx_en = clr | (tick & run);
    idx_d  = clr ? '0 : idx + FIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end

  for (genvar b = 0; b < LOG2MAX; b++) begin : g_keep
    assign keep[b] = ({29'd0, code} + 32'(b)) < 32'(LOG2MAX);
  end

  assign offset = {idx[LOG2MAX-1:0] & keep, 2'b00};

  // R10: index holds without a running tick, steps by one with it
  p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(tick && run)) |=> $stable(idx));
  p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && run) |=> (idx == FIDX_W'($past(idx) + 1'b1)));
endmodule

// File: rtl/usbh_cmdsts.sv
module usbh_cmdsts
  import usbh_cs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned FIDX_W      = 14,
  parameter int unsigned FL_LOG2_MAX = 10,
  parameter int unsigned RST_CYC     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   cap_prog_fl,
  input  logic                   xact_busy,
  input  logic                   frame_tick,
  input  logic [NFLAG-1:0]       evt_set,
  output logic                   sched_run,
  output logic                   periodic_en,
  output logic                   soft_rst,
  output logic [FL_LOG2_MAX+1:0] fl_offset
);
  logic              wr_cmd, wr_sts, rst_start, cmd_upd, sts_upd;
  logic              halted;
  logic              pen_q, pen_d;
  fl_code_t          fs_q, fs_d;
  logic              fs_en;
  logic [NFLAG-1:0]  flag_q, flag_d;
  logic [FIDX_W-1:0] fidx;
  logic [31:0]       cmd_rd, sts_rd;

  assign wr_cmd    = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
  assign wr_sts    = reg_wr && (reg_addr == ADDR_W'(OFS_STS));
  assign rst_start = wr_cmd && reg_wdata[B_RST] && !soft_rst;
  assign cmd_upd   = wr_cmd && !reg_wdata[B_RST] && !soft_rst;
  assign sts_upd   = wr_sts && !soft_rst;

  usbh_rstseq #(.CYCLES(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .active(soft_rst)
  );

  usbh_runctl u_run (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr_cmd(cmd_upd),
    .wr_run(reg_wdata[B_RUN]), .busy(xact_busy & ~soft_rst),
    .run(sched_run), .halted(halted)
  );

  usbh_frindex #(.FIDX_W(FIDX_W), .LOG2MAX(FL_LOG2_MAX)) u_fidx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(frame_tick),
    .run(sched_run), .code(fs_q), .idx(fidx), .offset(fl_offset)
  );

  // command fields
  always_comb begin
    pen_d = pen_q;
    fs_d  = fs_q;
    fs_en = 1'b0;
    if (soft_rst) begin
      pen_d = 1'b0;
      fs_d  = '0;
      fs_en = 1'b1;
    end else if (cmd_upd) begin
      pen_d = reg_wdata[B_PEN];
      if (cap_prog_fl) begin
        fs_d  = {reg_wdata[B_FS2], reg_wdata[B_FS1], reg_wdata[B_FS0]};
        fs_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= 1'b0;
      fs_q  <= '0;
    end else begin
      pen_q <= pen_d;
      if (fs_en) fs_q <= fs_d;
    end
  end

  // status flags
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      if (soft_rst) flag_d[i] = 1'b0;
      else          flag_d[i] = (flag_q[i] & ~(sts_upd & reg_wdata[i])) | evt_set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    // R12: a set pulse outside reset always leaves the flag set
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set[i] && !soft_rst) |=> flag_q[i]);
  end

  assign periodic_en = pen_q;

  // read mux
  always_comb begin
    cmd_rd         = '0;
    cmd_rd[B_RUN]  = sched_run;
    cmd_rd[B_RST]  = soft_rst;
    cmd_rd[B_FS0]  = fs_q[0];
    cmd_rd[B_FS1]  = fs_q[1];
    cmd_rd[B_PEN]  = pen_q;
    cmd_rd[B_FS2]  = fs_q[2];
    sts_rd         = '0;
    sts_rd[NFLAG-1:0] = flag_q;
    sts_rd[B_HALT] = halted;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(OFS_CMD):  reg_rdata = cmd_rd;
      ADDR_W'(OFS_STS):  reg_rdata = sts_rd;
      ADDR_W'(OFS_FIDX): reg_rdata = 32'(fidx);
      default:           reg_rdata = '0;
    endcase
  end

  // R9: without the capability the size code never moves
  p_fs_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_prog_fl && !soft_rst) |=> (fs_q == $past(fs_q)));
  // R6: reset clears run and periodic enable
  p_rst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!sched_run && !periodic_en));
  // R5: running and halted are never both reported for two cycles
  p_run_not_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_run && $past(sched_run)) |-> !halted);
endmodule

// File: tb/tb_usbh_cmdsts.sv
module tb_usbh_cmdsts;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cap_prog_fl, xact_busy, frame_tick;
  logic [5:0]  evt_set;
  logic        sched_run, periodic_en, soft_rst;
  logic [11:0] fl_offset;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int exp_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_cmdsts dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_prog_fl(cap_prog_fl),
    .xact_busy(xact_busy), .frame_tick(frame_tick), .evt_set(evt_set),
    .sched_run(sched_run), .periodic_en(periodic_en), .soft_rst(soft_rst),
    .fl_offset(fl_offset)
  );

  localparam logic [11:0] A_CMD = 12'h140, A_STS = 12'h144, A_FIDX = 12'h14C;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] fs_bits(input int c);
    return (32'(c >> 2 & 1) << 15) | (32'(c >> 1 & 1) << 3) | (32'(c & 1) << 2);
  endfunction

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    cap_prog_fl = 1'b1; xact_busy = 0; frame_tick = 0; evt_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CMD, v); chk("R1 cmd", v, 32'h0);
    rd(A_STS, v); chk("R1 sts", v, 32'h0000_1000);
    chk("R1 outs", {29'd0, sched_run, periodic_en, soft_rst}, 32'h0);
    // R2 map
    rd(12'h148, v); chk("R2 unmapped", v, 32'h0);
    rd(A_FIDX, v);  chk("R2 fidx", v, 32'h0);

    // R9 capability gate
    cap_prog_fl = 1'b0;
    wr(A_CMD, fs_bits(7));
    rd(A_CMD, v); chk("R9 locked", v, 32'h0);
    cap_prog_fl = 1'b1;
    wr(A_CMD, fs_bits(7));
    rd(A_CMD, v); chk("R9 R2 code7", v, 32'h0000_800C);
    wr(A_CMD, fs_bits(5));
    rd(A_CMD, v); chk("R9 code5", v, 32'h0000_8004);
    wr(A_CMD, 32'h0);

    // R8 periodic enable
    wr(A_CMD, 32'h10);
    chk("R8 pen on", {31'd0, periodic_en}, 32'h1);
    rd(A_CMD, v); chk("R8 readback", v, 32'h10);
    wr(A_CMD, 32'h0);
    chk("R8 pen off", {31'd0, periodic_en}, 32'h0);

    // R12 flags: set, clear, write-0, set wins
    for (int i = 0; i < 6; i++) begin
      evt_set = 6'(1 << i); @(negedge clk); evt_set = '0;
      rd(A_STS, v); chk("R12 set", v, 32'h1000 | 32'(1 << i));
      wr(A_STS, 32'h0);
      rd(A_STS, v); chk("R12 write0", v, 32'h1000 | 32'(1 << i));
      evt_set = 6'(1 << i); wr(A_STS, 32'(1 << i)); evt_set = '0;
      rd(A_STS, v); chk("R12 set wins", v, 32'h1000 | 32'(1 << i));
      wr(A_STS, 32'(1 << i));
      rd(A_STS, v); chk("R12 clear", v, 32'h1000);
    end

    // R3 start
    wr(A_CMD, 32'h1);
    chk("R3 run", {31'd0, sched_run}, 32'h1);
    rd(A_STS, v); chk("R3 halted still set", v, 32'h1000);
    @(negedge clk);
    rd(A_STS, v); chk("R3 halted clear", v, 32'h0);

    // R10/R11 sweep across counter wrap
    exp_idx = 0;
    frame_tick = 1'b1;
    for (int t = 1; t <= 16400; t++) begin
      @(negedge clk);
      exp_idx = (exp_idx + 1) % 16384;
      rd(A_FIDX, v); chk("R10 idx", v, 32'(exp_idx));
      if (t % 700 == 0 || t == 16383 || t == 16384) begin
        frame_tick = 1'b0;
        for (int c = 0; c < 8; c++) begin
          wr(A_CMD, 32'h1 | fs_bits(c));
          chk("R11 offset", 32'(fl_offset), 32'((exp_idx % (1024 >> c)) * 4));
        end
        rd(A_FIDX, v); chk("R10 hold", v, 32'(exp_idx));
        frame_tick = 1'b1;
      end
    end
    frame_tick = 1'b0;
    @(negedge clk);

    // R4/R5 stop handshake
    xact_busy = 1'b1;
    wr(A_CMD, 32'h0);
    chk("R5 run drop", {31'd0, sched_run}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rd(A_STS, v); chk("R5 wait busy", v, 32'h0);
    end
    wr(A_CMD, 32'h1);
    chk("R4 restart ignored", {31'd0, sched_run}, 32'h0);
    xact_busy = 1'b0;
    rd(A_STS, v); chk("R5 not yet", v, 32'h0);
    @(negedge clk);
    rd(A_STS, v); chk("R5 halted", v, 32'h1000);
    // R10 no count while halted
    rd(A_FIDX, v);
    exp_idx = int'(v);
    frame_tick = 1'b1; repeat (5) @(negedge clk); frame_tick = 1'b0;
    rd(A_FIDX, v); chk("R10 halted hold", v, 32'(exp_idx));

    // R6/R7 soft reset
    wr(A_CMD, 32'h1);
    @(negedge clk);
    frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
    wr(A_CMD, 32'h1_0011 & 32'hFFFF);
    evt_set = 6'h3F; @(negedge clk); evt_set = '0;
    xact_busy = 1'b1;
    wr(A_CMD, 32'h2);
    n = 0;
    for (int i = 0; i < 22; i++) begin
      if (soft_rst) begin
        n++;
        rd(A_CMD, v); chk("R6 rst bit", v & 32'h2, 32'h2);
      end
      reg_wr = 1'b0; evt_set = '0;
      case (i)
        1: begin reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h0; end
        3: begin reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h8011; end
        5: evt_set = 6'h3F;
        7: begin reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h0; end
        default: ;
      endcase
      @(negedge clk);
    end
    reg_wr = 1'b0; evt_set = '0;
    chk("R6 R7 length", 32'(n), 32'd16);
    rd(A_CMD, v);  chk("R6 R7 cmd after", v, 32'h0);
    rd(A_STS, v);  chk("R6 R7 sts after", v, 32'h1000);
    rd(A_FIDX, v); chk("R6 fidx after", v, 32'h0);
    chk("R7 outs", {30'd0, sched_run, periodic_en}, 32'h0);
    xact_busy = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule